// File: doc/BRIEF.md
# Prescaled PWM Channel with Shadowed Settings

This block produces one pulse-width-modulated output. The input clock is first halved, then split further by a 16-bit prescaler. Each prescaled tick advances an 8-bit up-counter. The counter is compared with an active period value and an active width value. The output is high while the count is below the width. The counter wraps to zero when it matches the period, and that starts the next pulse.

Software reaches the block through a single-cycle register write strobe. A write lands in a holding copy of the prescaler, width or period. The running channel keeps its active copies until the current period ends, and only then takes the holding values. A new waveform therefore never starts partway through a pulse.

There are two control inputs. One enables the channel. The other inverts the output. Neither carries streamed data, so both are plain level inputs with no handshake.

Top module: `pwm_shadow`

## Requirements
- R1: With an active prescaler value P, the counter advances exactly once every 2*(P+1) input clocks. P = 0 gives the fastest rate of one step every 2 clocks.
- R2: The counter counts up from 0 to the active period value N and then clears to 0. One period therefore lasts (N+1)*2*(P+1) clocks, and the counter never holds a value above N while enabled.
- R3: With `invert` = 0, `pwm_out` is 1 while the count is below the active width W and 0 once the count is equal to or above W. The high time is W*2*(P+1) clocks.
- R4: The output returns high in the cycle the counter clears after a period match, so consecutive rising edges are exactly one period apart.
- R5: When `wr_en` is 1, `wr_data` is stored in a holding register chosen by `wr_sel`: 0 selects the prescaler (16 bits), 1 selects the width (low 8 bits), 2 selects the period (low 8 bits). A write made while the channel runs leaves the current period unchanged and takes effect from the next period.
- R6: While `enable` is 0, the active values follow the holding values. The first period after `enable` rises therefore already uses the latest written settings, and it is timed from the clock edge that first samples `enable` high.
- R7: With `invert` = 1, the enabled output is the bitwise complement of the R3 waveform.
- R8: While `enable` is 0, the counter and prescaler are held at zero and `pwm_out` equals `invert`.
- R9: A period setting that breaks the rules still runs without lock-up. For example, period 0 with width 1 wraps on every tick and keeps the output constantly high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the holding registers |
| wr_sel | input | 2 | Holding register select: 0 prescaler, 1 width, 2 period |
| wr_data | input | 16 | Write data; width and period take the low 8 bits |
| enable | input | 1 | Channel run control |
| invert | input | 1 | Output polarity select |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach from the ports is a write that arrives while a period is already in flight. Seen from outside, a write applied at once and a write held until the wrap look the same unless the timing is measured on both sides of the boundary. The bench waits for a rising output edge and then issues the width and period writes in the next two cycles, while it is still timing that pulse. It then checks that this period keeps the old high time and length and that the following period shows the new ones. To separate the enable-time load from the wrap-time load, a second scenario rewrites the settings while the channel is disabled and times the very first pulse after `enable` rises.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  typedef enum logic [1:0] {
    SEL_PRESCALE = 2'd0,
    SEL_WIDTH    = 2'd1,
    SEL_PERIOD   = 2'd2,
    SEL_NONE     = 2'd3
  } pwm_sel_e;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_lim,
  output logic             tick
);
  logic             half_q;
  logic [PRE_W-1:0] pre_q;
  logic             half_en;

  assign half_en = run & half_q;
  assign tick    = half_en & (pre_q == pre_lim);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      half_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      half_q <= ~half_q;
      if (half_en) pre_q <= tick ? '0 : pre_q + 1'b1;
    end
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pwm_cmp_core.sv
module pwm_cmp_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_lim,
  input  logic [CNT_W-1:0] wid_lim,
  output logic             period_end,
  output logic             high
);
  logic [CNT_W-1:0] cnt_q;

  assign period_end = tick & (cnt_q == per_lim);
  assign high       = (cnt_q < wid_lim);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= period_end ? '0 : cnt_q + 1'b1;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= per_lim));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    period_end |=> (cnt_q == '0));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_shadow_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [PRE_W-1:0] wr_data,
  input  logic             run,
  input  logic             period_end,
  output logic [PRE_W-1:0] act_pre,
  output logic [CNT_W-1:0] act_wid,
  output logic [CNT_W-1:0] act_per
);
  logic [PRE_W-1:0] hold_pre;
  logic [CNT_W-1:0] hold_wid;
  logic [CNT_W-1:0] hold_per;
  logic             reload;

  assign reload = !run || period_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_pre <= '0;
      hold_wid <= '0;
      hold_per <= '0;
    end else if (wr_en) begin
      case (pwm_sel_e'(wr_sel))
        SEL_PRESCALE: hold_pre <= wr_data;
        SEL_WIDTH:    hold_wid <= wr_data[CNT_W-1:0];
        SEL_PERIOD:   hold_per <= wr_data[CNT_W-1:0];
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_pre <= '0;
      act_wid <= '0;
      act_per <= '0;
    end else if (reload) begin
      act_pre <= hold_pre;
      act_wid <= hold_wid;
      act_per <= hold_per;
    end
  end

  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !period_end) |=> ($stable(act_pre) && $stable(act_wid) && $stable(act_per)));
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int PRE_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [PRE_W-1:0] wr_data,
  input  logic             enable,
  input  logic             invert,
  output logic             pwm_out
);
  logic [PRE_W-1:0] act_pre;
  logic [CNT_W-1:0] act_wid;
  logic [CNT_W-1:0] act_per;
  logic             tick;
  logic             period_end;
  logic             high;

  pwm_shadow_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .run(enable), .period_end(period_end),
    .act_pre(act_pre), .act_wid(act_wid), .act_per(act_per)
  );

  pwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst(rst), .run(enable), .pre_lim(act_pre), .tick(tick)
  );

  pwm_cmp_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run(enable), .tick(tick),
    .per_lim(act_per), .wid_lim(act_wid),
    .period_end(period_end), .high(high)
  );

  assign pwm_out = enable ? (high ^ invert) : invert;

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (pwm_out == invert));
endmodule

// File: tb/pwm_shadow_bench.sv
`timescale 1ns/1ps
module pwm_shadow_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        enable = 1'b0;
  logic        invert = 1'b0;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_shadow u_pwm_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .enable(enable), .invert(invert), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // The current sample counts as the first active sample. Returns once
  // the next rising (active) edge has been sampled.
  task automatic measure(input bit inv, output int hi, output int per);
    int lo;
    hi = 1; lo = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); #1;
      if ((pwm_out ^ inv) && lo == 0) hi++;
      else if (!(pwm_out ^ inv)) lo++;
      else break;
    end
    per = hi + lo;
  endtask

  task automatic setup_and_start(input int p, input int w, input int n, input bit inv);
    @(negedge clk);
    enable = 1'b0; invert = inv;
    wr(2'd0, p); wr(2'd1, w); wr(2'd2, n);
    @(negedge clk);
    enable = 1'b1;
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R8 reset level", int'(pwm_out), 0);
  endtask

  task automatic t_basic(input int p, input int w, input int n);
    int hi, per;
    setup_and_start(p, w, n, 1'b0);
    measure(1'b0, hi, per);
    chk("R3 high time first", hi, w * 2 * (p + 1));
    chk("R2 period first", per, (n + 1) * 2 * (p + 1));
    measure(1'b0, hi, per);
    chk("R1 high time steady", hi, w * 2 * (p + 1));
    chk("R4 rise-to-rise period", per, (n + 1) * 2 * (p + 1));
  endtask

  task automatic t_midwrite;
    int hi, per;
    setup_and_start(1, 2, 9, 1'b0);
    measure(1'b0, hi, per);
    fork
      begin
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd6;
        @(negedge clk);
        wr_sel = 2'd2; wr_data = 16'd12;
        @(negedge clk);
        wr_en = 1'b0;
      end
      measure(1'b0, hi, per);
    join
    chk("R5 current period keeps width", hi, 8);
    chk("R5 current period keeps length", per, 40);
    measure(1'b0, hi, per);
    chk("R5 next period new width", hi, 24);
    chk("R5 next period new length", per, 52);
  endtask

  task automatic t_enable_load;
    int hi, per;
    @(negedge clk);
    enable = 1'b0;
    #1;
    chk("R8 disabled level low", int'(pwm_out), 0);
    setup_and_start(0, 4, 5, 1'b0);
    measure(1'b0, hi, per);
    chk("R6 first pulse new width", hi, 8);
    chk("R6 first period new length", per, 12);
  endtask

  task automatic t_invert;
    int hi, per;
    @(negedge clk);
    enable = 1'b0; invert = 1'b1;
    #1;
    chk("R8 disabled level inverted", int'(pwm_out), 1);
    setup_and_start(0, 3, 7, 1'b1);
    measure(1'b1, hi, per);
    chk("R7 inverted active time", hi, 6);
    chk("R7 inverted period", per, 16);
  endtask

  task automatic t_bad_period;
    int lows;
    lows = 0;
    setup_and_start(0, 1, 0, 1'b0);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #1;
      if (!pwm_out) lows++;
    end
    chk("R9 zero period stays high", lows, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic(0, 3, 9);
    t_basic(2, 5, 7);
    t_basic(1, 1, 4);
    t_midwrite();
    t_enable_load();
    t_invert();
    t_bad_period();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule